// File: doc/BRIEF.md
# UART FIFO Status and Interrupt Unit

This unit sits between the byte-level serial engine of a memory-mapped UART and the host register bus. It holds a receive queue and a transmit queue of bytes. From their fill levels it derives a live status word, and it folds that word every cycle into a sticky interrupt-status word that software clears by writing ones. A programmable mask selects which sticky bits drive the single interrupt line.

Received bytes arrive on a strobe input with an advisory ready output. Which queues a received byte enters depends on the channel mode. In normal mode it enters the receive queue. In echo mode it enters both queues. In remote loopback it enters only the transmit queue, so the byte goes straight back out. A byte that is offered while ready is low is lost and flagged as an overrun. The transmit queue drains through a valid/ready byte output. An idle timer flags a receive timeout when four programmable character times pass without another accepted byte.

Register word addresses on `reg_addr`:
- 0: control, read/write, resets to 0x128.
- 1: channel mode, read/write, bits [1:0].
- 2: interrupt mask, read/write, all 32 bits.
- 3: interrupt status, reads the sticky word; a write clears the bits written as one.
- 4: live status, read-only.
- 5: data. A read returns the oldest received byte and removes it. A write adds a byte to the transmit queue.
- 6: receive trigger level, read/write.
- 7: transmit trigger level, read/write.
- 8: character time in clock cycles, read/write.

Reads of any other address return zero.

Top module: `uart_fifo_irq`

## Requirements
- R1: After reset the control register reads 0x128, the mask and interrupt-status words read 0, both queues are empty, both trigger levels read DEPTH/2 and the character time reads CT_RESET.
- R2: The live status word (address 4) has these bits: bit 0 is set when the receive count is at or above the receive trigger level; bit 1 when the receive queue is empty; bit 2 when it is full; bit 3 when the transmit queue is empty; bit 4 when it is full; and bit 13 when the transmit count is at or above the transmit trigger level. All other bits read 0.
- R3: On every clock the status bits 4:0 are ORed into interrupt-status bits 4:0, and status bit 13 is ORed into interrupt-status bit 10. Writing address 3 clears each bit written as one, and a set in the same cycle wins over the clear.
- R4: `irq` is high exactly when any bit of (mask AND interrupt-status) is set.
- R5: Mode field bits [1:0] have these encodings: 0 and 3 are normal, 1 is echo and 2 is remote loopback. `rx_ready` requires receive-queue room in normal mode, room in both queues in echo mode, and only transmit-queue room in remote loopback.
- R6: An accepted received byte enters the receive queue in normal mode, both queues in echo mode, and only the transmit queue in remote loopback. In remote loopback the receive count does not change.
- R7: A byte offered on `rx_valid` while `rx_ready` is low is discarded and sets interrupt-status bit 5.
- R8: In normal mode a write to address 5 while the transmit queue is full is discarded and sets interrupt-status bit 5. In echo and remote loopback modes, writes to address 5 are ignored and raise no flag.
- R9: A read of address 5 returns the oldest received byte in bits [7:0] and removes it. When the receive queue is empty the read returns 0 and removes nothing.
- R10: Interrupt-status bit 8 is set once 4×CT clock cycles pass after an accepted received byte with no further accepted byte, where CT is the character-time register. A CT of 0 gives a one-cycle window.
- R11: `tx_valid` is high while the transmit queue holds a byte. `tx_data` shows the oldest byte, and a cycle with `tx_ready` high removes it.
- R12: Each queue keeps first-in first-out order and holds exactly DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 5) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the current state |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Advisory: a byte offered now will be kept |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | DATA_W | Oldest transmit byte |
| tx_ready | input | 1 | Serialiser takes the transmit byte this cycle |
| irq | output | 1 | Masked interrupt output |

## Verification
The embedded checks assume that the register bus never reads and writes in the same cycle, and that `reg_addr` is stable whenever a strobe is high. The bench follows both rules: it drives one strobe at a time from tasks and changes inputs only half a cycle away from the active edge. `rx_valid` may be offered while `rx_ready` is low, and the stimulus does this on purpose, because dropping such a byte is a defined behaviour rather than an illegal input. The queue-level checks also assume that the surrounding logic never pushes into a full queue or pops an empty one, so the stimulus tests the overflow paths only through the gated entry points.

// File: rtl/ufsi_pkg.sv
package ufsi_pkg;

   typedef enum logic [1:0] {
      CH_NORMAL = 2'd0,
      CH_ECHO   = 2'd1,
      CH_REMOTE = 2'd2,
      CH_ALT    = 2'd3
   } chmode_e;

   typedef enum logic [3:0] {
      RA_CTRL   = 4'd0,
      RA_MODE   = 4'd1,
      RA_IMASK  = 4'd2,
      RA_ISR    = 4'd3,
      RA_STATUS = 4'd4,
      RA_DATA   = 4'd5,
      RA_RXLVL  = 4'd6,
      RA_TXLVL  = 4'd7,
      RA_CHART  = 4'd8
   } regaddr_e;

   // live status bit positions
   localparam int ST_RX_TRIG  = 0;
   localparam int ST_RX_EMPTY = 1;
   localparam int ST_RX_FULL  = 2;
   localparam int ST_TX_EMPTY = 3;
   localparam int ST_TX_FULL  = 4;
   localparam int ST_TX_TRIG  = 13;

   // sticky interrupt bit positions beyond the mirrored low five
   localparam int IS_OVERRUN  = 5;
   localparam int IS_TIMEOUT  = 8;
   localparam int IS_TX_TRIG  = 10;

   localparam logic [31:0] CTRL_RESET = 32'h0000_0128;

endpackage

// File: rtl/ufsi_fifo.sv
module ufsi_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CNT_W-1:0] count
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ufsi_fifo: DEPTH must be at least 2");
      end
      if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt
         $error("ufsi_fifo: CNT_W too narrow for DEPTH");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign head = mem[rd_ptr];

   // R12: the enclosing logic gates pushes and pops on the count
   assert_push_has_room_R12: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < FULL_CNT));
   assert_pop_has_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0));

endmodule

// File: rtl/ufsi_idle_timer.sv
module ufsi_idle_timer #(
   parameter int CT_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rearm,
   input  logic [CT_W-1:0] char_time,
   output logic            fire
);

   localparam int LIM_W = CT_W + 2;

   generate
      if (CT_W < 1 || CT_W > 28) begin : g_bad_ct
         $error("ufsi_idle_timer: CT_W out of range");
      end
   endgenerate

   logic [LIM_W-1:0] limit, cnt;
   logic             armed;

   assign limit = (char_time == '0) ? LIM_W'(1) : {char_time, 2'b00};
   assign fire  = armed && (cnt >= limit - LIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (rearm) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (armed) begin
         if (fire) armed <= 1'b0;
         else      cnt   <= cnt + LIM_W'(1);
      end
   end

endmodule

// File: rtl/ufsi_irq_ctrl.sv
module ufsi_irq_ctrl
   import ufsi_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_lvl,
   input  logic [CNT_W-1:0] tx_lvl,
   input  logic             ovf_evt,
   input  logic             tmo_evt,
   input  logic             clr_en,
   input  logic [31:0]      clr_bits,
   input  logic [31:0]      mask,
   output logic [31:0]      status,
   output logic [31:0]      isr,
   output logic             irq
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [31:0] set_bits, clr_now;

   always_comb begin
      status = '0;
      status[ST_RX_TRIG]  = (rx_count >= rx_lvl);
      status[ST_RX_EMPTY] = (rx_count == '0);
      status[ST_RX_FULL]  = (rx_count == FULL_CNT);
      status[ST_TX_EMPTY] = (tx_count == '0);
      status[ST_TX_FULL]  = (tx_count == FULL_CNT);
      status[ST_TX_TRIG]  = (tx_count >= tx_lvl);
   end

   always_comb begin
      set_bits = '0;
      set_bits[4:0]       = status[4:0];
      set_bits[IS_TX_TRIG] = status[ST_TX_TRIG];
      set_bits[IS_OVERRUN] = ovf_evt;
      set_bits[IS_TIMEOUT] = tmo_evt;
      clr_now = clr_en ? clr_bits : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) isr <= '0;
      else        isr <= (isr & ~clr_now) | set_bits;
   end

   assign irq = |(mask & isr);

   // R3: live flags reach the sticky word one edge later, set wins over clear
   assert_sticky_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_RX_EMPTY] |=> isr[ST_RX_EMPTY]);
   assert_txtrig_remap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_TX_TRIG] |=> isr[IS_TX_TRIG]);
   assert_overflow_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> isr[IS_OVERRUN]);
   assert_timeout_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_evt |=> isr[IS_TIMEOUT]);

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
   import ufsi_pkg::*;
#(
   parameter int DEPTH    = 64,
   parameter int DATA_W   = 8,
   parameter int CT_W     = 16,
   parameter int CT_RESET = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   output logic              irq
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LVL_RESET = CNT_W'(DEPTH / 2);

   generate
      if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
         $error("uart_fifo_irq: DATA_W must be 1..32");
      end
      if (CNT_W > 32) begin : g_bad_depth
         $error("uart_fifo_irq: DEPTH too large");
      end
   endgenerate

   // ---------------- register file ----------------
   logic [31:0]      ctrl_q, mask_q;
   chmode_e          mode_q;
   logic [CNT_W-1:0] rxlvl_q, txlvl_q;
   logic [CT_W-1:0]  chart_q;

   logic wr_hit [9];
   always_comb begin
      for (int i = 0; i < 9; i++) wr_hit[i] = reg_wr && (reg_addr == 4'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RESET;
         mode_q  <= CH_NORMAL;
         mask_q  <= '0;
         rxlvl_q <= LVL_RESET;
         txlvl_q <= LVL_RESET;
         chart_q <= CT_W'(CT_RESET);
      end else begin
         if (wr_hit[RA_CTRL])  ctrl_q  <= reg_wdata;
         if (wr_hit[RA_MODE])  mode_q  <= chmode_e'(reg_wdata[1:0]);
         if (wr_hit[RA_IMASK]) mask_q  <= reg_wdata;
         if (wr_hit[RA_RXLVL]) rxlvl_q <= reg_wdata[CNT_W-1:0];
         if (wr_hit[RA_TXLVL]) txlvl_q <= reg_wdata[CNT_W-1:0];
         if (wr_hit[RA_CHART]) chart_q <= reg_wdata[CT_W-1:0];
      end
   end

   // ---------------- routing and flow control ----------------
   logic [CNT_W-1:0]  rx_count, tx_count;
   logic [DATA_W-1:0] rx_head, tx_head, tx_wdata;
   logic feeds_rx, feeds_tx, rx_room, tx_room;
   logic rx_take, rx_drop, host_tx_wr, host_push, host_drop;
   logic rx_push, tx_push, rx_pop, tx_pop, ovf_evt, tmo_evt;

   always_comb begin
      case (mode_q)
         CH_ECHO:   begin feeds_rx = 1'b1; feeds_tx = 1'b1; end
         CH_REMOTE: begin feeds_rx = 1'b0; feeds_tx = 1'b1; end
         default:   begin feeds_rx = 1'b1; feeds_tx = 1'b0; end
      endcase
   end

   assign rx_room    = (rx_count < FULL_CNT);
   assign tx_room    = (tx_count < FULL_CNT);
   assign rx_ready   = (!feeds_rx || rx_room) && (!feeds_tx || tx_room);
   assign rx_take    = rx_valid && rx_ready;
   assign rx_drop    = rx_valid && !rx_ready;

   assign host_tx_wr = wr_hit[RA_DATA] && !feeds_tx;
   assign host_push  = host_tx_wr && tx_room;
   assign host_drop  = host_tx_wr && !tx_room;

   assign rx_push    = rx_take && feeds_rx;
   assign tx_push    = (rx_take && feeds_tx) || host_push;
   assign tx_wdata   = feeds_tx ? rx_data : reg_wdata[DATA_W-1:0];
   assign rx_pop     = reg_rd && (reg_addr == RA_DATA) && (rx_count != '0);
   assign tx_pop     = tx_ready && (tx_count != '0);
   assign ovf_evt    = rx_drop || host_drop;

   assign tx_valid   = (tx_count != '0);
   assign tx_data    = tx_head;

   // ---------------- submodules ----------------
   ufsi_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W), .CNT_W(CNT_W)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .wdata (rx_data),
      .pop   (rx_pop),
      .head  (rx_head),
      .count (rx_count)
   );

   ufsi_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W), .CNT_W(CNT_W)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push),
      .wdata (tx_wdata),
      .pop   (tx_pop),
      .head  (tx_head),
      .count (tx_count)
   );

   ufsi_idle_timer #(.CT_W(CT_W)) u_idle (
      .clk       (clk),
      .rst_n     (rst_n),
      .rearm     (rx_take),
      .char_time (chart_q),
      .fire      (tmo_evt)
   );

   logic [31:0] status_w, isr_w;

   ufsi_irq_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_count (rx_count),
      .tx_count (tx_count),
      .rx_lvl   (rxlvl_q),
      .tx_lvl   (txlvl_q),
      .ovf_evt  (ovf_evt),
      .tmo_evt  (tmo_evt),
      .clr_en   (wr_hit[RA_ISR]),
      .clr_bits (reg_wdata),
      .mask     (mask_q),
      .status   (status_w),
      .isr      (isr_w),
      .irq      (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      case (reg_addr)
         RA_CTRL:   reg_rdata = ctrl_q;
         RA_MODE:   reg_rdata = {30'd0, mode_q};
         RA_IMASK:  reg_rdata = mask_q;
         RA_ISR:    reg_rdata = isr_w;
         RA_STATUS: reg_rdata = status_w;
         RA_DATA:   reg_rdata = (rx_count == '0) ? '0 : 32'(rx_head);
         RA_RXLVL:  reg_rdata = 32'(rxlvl_q);
         RA_TXLVL:  reg_rdata = 32'(txlvl_q);
         RA_CHART:  reg_rdata = 32'(chart_q);
         default:   reg_rdata = '0;
      endcase
   end

   // R6: remote loopback bypasses the receive queue entirely
   assert_remote_keeps_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CH_REMOTE && !rx_pop) |=> (rx_count == $past(rx_count)));

   // R5: an echo-mode acceptance needs room on both sides
   assert_echo_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CH_ECHO && rx_take) |-> (rx_count < FULL_CNT && tx_count < FULL_CNT));

endmodule

// File: tb/uart_fifo_irq_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_tb;

   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, tx_ready = 1'b0, irq;
   logic [7:0]  tx_data;

   always #2.5 clk = ~clk;

   uart_fifo_irq u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
   );

   // ---------------- reference model ----------------
   logic [7:0]  rxq[$];
   logic [7:0]  txq[$];
   int unsigned m_isr, m_mask, m_ctrl, m_mode, m_rxlvl, m_txlvl, m_ct;
   bit          m_armed;
   int unsigned m_cnt;

   int    n_checks = 0, n_fail = 0;
   string cur_tag = "R1";
   bit    done = 1'b0;

   function automatic int unsigned m_status();
      int unsigned s = 0;
      int unsigned rn = rxq.size(), tn = txq.size();
      if (rn >= m_rxlvl) s |= 32'h1;
      if (rn == 0)       s |= 32'h2;
      if (rn == DEPTH)   s |= 32'h4;
      if (tn == 0)       s |= 32'h8;
      if (tn == DEPTH)   s |= 32'h10;
      if (tn >= m_txlvl) s |= 32'h2000;
      return s;
   endfunction

   function automatic bit f_rx(); return m_mode != 2; endfunction
   function automatic bit f_tx(); return m_mode == 1 || m_mode == 2; endfunction

   function automatic bit m_ready();
      return (!f_rx() || rxq.size() < DEPTH) && (!f_tx() || txq.size() < DEPTH);
   endfunction

   function automatic int unsigned m_rdata();
      case (reg_addr)
         4'd0: return m_ctrl;
         4'd1: return m_mode;
         4'd2: return m_mask;
         4'd3: return m_isr;
         4'd4: return m_status();
         4'd5: return (rxq.size() == 0) ? 0 : rxq[0];
         4'd6: return m_rxlvl;
         4'd7: return m_txlvl;
         4'd8: return m_ct;
         default: return 0;
      endcase
   endfunction

   function automatic string addr_tag();
      case (reg_addr)
         4'd3: return "R3";
         4'd4: return "R2";
         4'd5: return "R9";
         default: return "R1";
      endcase
   endfunction

   task automatic m_reset();
      rxq.delete(); txq.delete();
      m_isr = 0; m_mask = 0; m_ctrl = 32'h128; m_mode = 0;
      m_rxlvl = DEPTH / 2; m_txlvl = DEPTH / 2; m_ct = 16;
      m_armed = 0; m_cnt = 0;
   endtask

   task automatic m_update();
      int unsigned st = m_status();
      int unsigned lim = (m_ct == 0) ? 1 : 4 * m_ct;
      int unsigned set = (st & 32'h1F) | (((st >> 13) & 1) << 10);
      int unsigned clr = 0;
      bit rdy = m_ready(), frx = f_rx(), ftx = f_tx();
      int unsigned rn = rxq.size(), tn = txq.size();
      bit fire = m_armed && (m_cnt >= lim - 1);
      bit ovf = 0;
      bit take = rx_valid && rdy;
      if (reg_rd && reg_addr == 4'd5 && rn > 0) void'(rxq.pop_front());
      if (tx_ready && tn > 0) void'(txq.pop_front());
      if (rx_valid && !rdy) ovf = 1;
      if (take) begin
         if (frx) rxq.push_back(rx_data);
         if (ftx) txq.push_back(rx_data);
      end
      if (reg_wr) begin
         case (reg_addr)
            4'd0: m_ctrl = reg_wdata;
            4'd1: m_mode = reg_wdata & 3;
            4'd2: m_mask = reg_wdata;
            4'd3: clr = reg_wdata;
            4'd5: if (!ftx) begin
                     if (tn < DEPTH) txq.push_back(reg_wdata[7:0]);
                     else ovf = 1;
                  end
            4'd6: m_rxlvl = reg_wdata & 32'h7F;
            4'd7: m_txlvl = reg_wdata & 32'h7F;
            4'd8: m_ct = reg_wdata & 32'hFFFF;
            default: ;
         endcase
      end
      if (take) begin m_armed = 1; m_cnt = 0; end
      else if (m_armed) begin
         if (fire) m_armed = 0;
         else m_cnt++;
      end
      m_isr = (m_isr & ~clr) | set | (32'(ovf) << 5) | (32'(fire) << 8);
   endtask

   task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s: actual %h expected %h at %0t", tag, cur_tag, what, act, exp, $time);
      end
   endtask

   // compare all outputs, then advance one clock with the model in step
   task automatic tick();
      logic [31:0] exp_tx;
      #1;
      cmp("R4", "irq", 32'(irq), 32'(|(m_mask & m_isr)));
      cmp("R5", "rx_ready", 32'(rx_ready), 32'(m_ready()));
      cmp("R11", "tx_valid", 32'(tx_valid), 32'(txq.size() != 0));
      if (txq.size() != 0) begin
         exp_tx = 32'(txq[0]);
         cmp("R11", "tx_data", 32'(tx_data), exp_tx);
      end
      cmp(addr_tag(), "reg_rdata", reg_rdata, m_rdata());
      @(posedge clk);
      m_update();
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
   endtask
   task automatic rd(input logic [3:0] a);
      reg_rd = 1; reg_addr = a; tick(); reg_rd = 0;
   endtask
   task automatic look(input logic [3:0] a);
      reg_addr = a; tick();
   endtask
   task automatic rxb(input logic [7:0] b);
      rx_valid = 1; rx_data = b; tick(); rx_valid = 0;
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset values
      cur_tag = "R1";
      look(4'd0); look(4'd2); look(4'd3); look(4'd6); look(4'd7); look(4'd8);
      // R9: empty read returns zero
      cur_tag = "R9";
      rd(4'd5); look(4'd4);
      // R12 / R2: fill transmit queue to its depth
      cur_tag = "R12";
      for (int i = 0; i < DEPTH; i++) wr(4'd5, 32'(i * 3 + 1));
      cur_tag = "R2"; look(4'd4);
      // R8: push into full transmit queue
      cur_tag = "R8"; wr(4'd5, 32'hAA); look(4'd3);
      // R3: write-one-to-clear, live flags come back
      cur_tag = "R3"; wr(4'd3, 32'hFFFF_FFFF); look(4'd3); idle(1); look(4'd3);
      // R11: drain in order
      cur_tag = "R11"; tx_ready = 1; idle(DEPTH + 2); tx_ready = 0;
      // R6 normal routing and R2 receive trigger
      cur_tag = "R6"; wr(4'd6, 3);
      for (int i = 0; i < 5; i++) rxb(8'h40 + 8'(i));
      look(4'd4);
      cur_tag = "R9"; rd(4'd5); rd(4'd5); look(4'd4);
      // R7: overrun of the receive queue
      cur_tag = "R7";
      for (int i = 0; i < DEPTH; i++) rxb(8'(i) ^ 8'h5A);
      look(4'd3);
      // R4: masking
      cur_tag = "R4"; wr(4'd2, 32'h20); look(4'd3); wr(4'd3, 32'h20); look(4'd3);
      wr(4'd2, 32'h4); idle(2); wr(4'd2, 0);
      cur_tag = "R9";
      for (int i = 0; i < DEPTH; i++) rd(4'd5);
      // R5 echo mode, R8 host write ignored
      cur_tag = "R8"; wr(4'd1, 1); wr(4'd5, 32'h55); look(4'd3); look(4'd4);
      cur_tag = "R5";
      for (int i = 0; i < DEPTH + 1; i++) rxb(8'h80 + 8'(i));
      look(4'd4); look(4'd3);
      // R6 remote loopback
      cur_tag = "R6"; wr(4'd1, 2); rxb(8'hC1);
      tx_ready = 1; idle(3); tx_ready = 0;
      rxb(8'hC2); rxb(8'hC3); look(4'd4);
      tx_ready = 1; rxb(8'hC4); idle(2); tx_ready = 0;
      // R5 alias mode 3 behaves as normal
      cur_tag = "R5"; wr(4'd1, 3); rxb(8'hD0); rd(4'd5); rxb(8'hD1); look(4'd4);
      // R10 timeout window
      cur_tag = "R10"; wr(4'd3, 32'hFFFF_FFFF); wr(4'd8, 3); rxb(8'hE0);
      idle(10); look(4'd3); look(4'd3); look(4'd3); look(4'd3);
      wr(4'd3, 32'h100); wr(4'd8, 0); rxb(8'hE1); look(4'd3); look(4'd3);
      // wind down
      cur_tag = "R11"; wr(4'd1, 0); tx_ready = 1; idle(DEPTH + 4);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule